// File: doc/BRIEF.md
# Match-Guided Literal Byte Decoder

This block recovers one 8-bit literal from a binary arithmetic-coded byte stream. It keeps a 768-entry table of adaptive bit probabilities. A reference byte, called the match byte, steers which table entries are used. While the bits decoded so far agree with the match byte, each bit reads its probability from one of two match-specific sub-trees, chosen by the next match bit. At the first disagreement the block drops back for good to the plain 256-entry tree. Every probability it reads is adapted toward the decoded bit and written back before the next bit.

After reset the block pulls the opening bytes of the stream into its code register. It then waits for a start pulse that carries the match byte. Each decoded bit costs one cycle. Whenever the interval width has fallen below 2^24, a bit step is first delayed so that one stream byte can be pulled in. Stream bytes come in over a valid/ready pair. When the literal is complete it is presented with a one-cycle done pulse. The probability table and the coder state carry over from one literal to the next, so a host can decode a run of literals back to back.

Top module: `lit_match_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, done is 0, literal is 0 and in_ready is 1, because the block is asking for its opening bytes.
- R2: After reset the block accepts exactly 5 stream bytes and shifts each into the low byte of the 32-bit code word. It then goes idle and drops in_ready. It accepts no stream byte while idle.
- R3: A start pulse is taken only when the block is idle. A start during the opening-byte phase or during a decode is ignored: it produces no extra done pulse and does not disturb the literal in progress.
- R4: Each bit is decoded as follows. bound = (range >> 11) * p, and the bit is 1 when code >= bound. On a 0: range = bound and p += (2048 - p) >> 5. On a 1: range -= bound, code -= bound and p -= p >> 5. Every probability starts at 1024 after reset.
- R5: Before each bit, if range < 2^24, the block takes one stream byte. It sets range = range << 8 and code = (code << 8) | byte, and it repeats this until range >= 2^24.
- R6: At start, symbol = 1 and the steering offset = 0x100. At each of the 8 steps, the match byte is shifted left by one, match_bit = shifted & offset (bit 8 only), and the table index is offset + match_bit + symbol. Afterwards, symbol = 2*symbol + bit.
- R7: After a step, a decoded 0 leaves offset & ~match_bit and a decoded 1 leaves offset & match_bit. Once offset is 0 it stays 0 for the rest of the literal, and every later index is below 0x100.
- R8: Every index used lies in 1..0x2FF. Each used entry is written back with its updated value in the same cycle as its bit. Table contents persist from one literal to the next.
- R9: After the 8th bit, literal shows the low 8 bits of the symbol, and done is high for exactly one cycle.
- R10: While the block needs a byte and in_valid is low, it holds its coder state and makes no progress. Stalls of any length leave the decoded literal unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin decoding one literal (taken when idle) |
| match_byte | input | 8 | Reference byte steering the probability choice |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Block takes in_data this cycle when in_valid is high |
| literal | output | 8 | Decoded literal, valid with done |
| done | output | 1 | One-cycle pulse: literal is complete |

## Verification
The bench holds an arithmetic encoder with its own probability model. It packs every target literal into one stream, and each decoded byte must equal the literal that was encoded. With this setup, a wrong index, offset update, adaptation step or normalization step desynchronizes the two models and garbles every literal that follows.

Literals equal to their match byte drive the index to the top of the table and keep the offset alive through all 8 bits. Literals that differ in bit 7, bit 4 or bit 0 clear the offset at the first, a middle or the last step. A decoder that failed to make the offset sticky, or that cleared it on a match, would read the wrong entries and decode the wrong byte. Long runs of one repeated literal push probabilities to their extremes, which exposes a wrong adaptation rounding or shift. Stray start pulses during the opening phase and mid-decode, together with randomly gapped and long-stalled byte delivery, expose a decoder that restarts early or that shifts in a byte without a handshake.

// File: rtl/lit_dec_pkg.sv
`timescale 1ns/1ps
package lit_dec_pkg;
  localparam int PROB_W      = 11;
  localparam int ADAPT_SHIFT = 5;
  localparam int WORD_W      = 32;
  localparam int BYTE_W      = 8;
  localparam int NORM_BIT    = 24;

  typedef logic [PROB_W-1:0] prob_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam prob_t PROB_HALF = prob_t'(1 << (PROB_W - 1));
  localparam word_t NORM_LIMIT = word_t'(1) << NORM_BIT;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_IDLE = 2'd1,
    ST_DEC  = 2'd2
  } phase_e;

  function automatic word_t split_point(word_t rng, prob_t p);
    return (rng >> PROB_W) * word_t'(p);
  endfunction

  function automatic prob_t adapt(prob_t p, logic bit_v);
    logic [PROB_W:0] full;
    logic [PROB_W:0] gap;
    full = {1'b1, {PROB_W{1'b0}}};
    gap  = full - {1'b0, p};
    if (bit_v)
      return p - (p >> ADAPT_SHIFT);
    else
      return p + prob_t'(gap >> ADAPT_SHIFT);
  endfunction

  function automatic logic needs_byte(word_t rng);
    return rng < NORM_LIMIT;
  endfunction
endpackage

// File: rtl/lit_prob_table.sv
`timescale 1ns/1ps
module lit_prob_table
  import lit_dec_pkg::*;
#(
  parameter int DEPTH = 768,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output prob_t            rd_prob,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  prob_t            wr_prob
);
  prob_t cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= PROB_HALF;
    end else if (wr_en) begin
      cells[wr_idx] <= wr_prob;
    end
  end

  assign rd_prob = cells[rd_idx];

  // R4: an adapted probability never collapses to 0 or reaches the full scale
  assert_prob_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_prob != '0 && wr_prob[PROB_W-1:0] != '1));
endmodule

// File: rtl/lit_bit_engine.sv
`timescale 1ns/1ps
module lit_bit_engine
  import lit_dec_pkg::*;
(
  input  word_t rng_i,
  input  word_t code_i,
  input  prob_t prob_i,
  output logic  bit_o,
  output word_t rng_o,
  output word_t code_o,
  output prob_t prob_o
);
  word_t bound;

  always_comb begin
    bound  = split_point(rng_i, prob_i);
    bit_o  = (code_i >= bound);
    rng_o  = bit_o ? (rng_i - bound) : bound;
    code_o = bit_o ? (code_i - bound) : code_i;
    prob_o = adapt(prob_i, bit_o);
  end
endmodule

// File: rtl/lit_match_steer.sv
`timescale 1ns/1ps
module lit_match_steer #(
  parameter int LIT_W = 8,
  parameter int IDX_W = LIT_W + 2
) (
  input  logic [LIT_W:0]   sym_i,
  input  logic [LIT_W:0]   off_i,
  input  logic [LIT_W:0]   mref_i,
  input  logic             bit_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [LIT_W:0]   mref_o,
  output logic [LIT_W:0]   sym_o,
  output logic [LIT_W:0]   off_o
);
  logic [LIT_W:0] mbit;

  function automatic logic [IDX_W-1:0] tree_index(logic [LIT_W:0] off,
                                                  logic [LIT_W:0] mb,
                                                  logic [LIT_W:0] sym);
    return IDX_W'(off) + IDX_W'(mb) + IDX_W'(sym);
  endfunction

  function automatic logic [LIT_W:0] next_offset(logic [LIT_W:0] off,
                                                 logic [LIT_W:0] mb,
                                                 logic b);
    return b ? (off & mb) : (off & ~mb);
  endfunction

  always_comb begin
    mref_o = {mref_i[LIT_W-1:0], 1'b0};
    mbit   = mref_o & off_i;
    idx_o  = tree_index(off_i, mbit, sym_i);
    sym_o  = {sym_i[LIT_W-1:0], bit_i};
    off_o  = next_offset(off_i, mbit, bit_i);
  end
endmodule

// File: rtl/lit_match_decoder.sv
`timescale 1ns/1ps
module lit_match_decoder
  import lit_dec_pkg::*;
#(
  parameter int LIT_W      = 8,
  parameter int INIT_BYTES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LIT_W-1:0] match_byte,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [LIT_W-1:0] literal,
  output logic             done
);
  localparam int IDX_W  = LIT_W + 2;
  localparam int DEPTH  = 3 << LIT_W;
  localparam int CNT_W  = (LIT_W > 1) ? $clog2(LIT_W) : 1;
  localparam int ICNT_W = (INIT_BYTES > 1) ? $clog2(INIT_BYTES) : 1;
  localparam logic [IDX_W-1:0] PLAIN_LIMIT = IDX_W'(1 << LIT_W);
  localparam logic [IDX_W-1:0] TOP_INDEX   = IDX_W'(DEPTH - 1);
  localparam logic [LIT_W:0]   OFF_START   = {1'b1, {LIT_W{1'b0}}};

  phase_e            st_q;
  word_t             rng_q, code_q;
  logic [LIT_W:0]    sym_q, off_q, mref_q;
  logic [CNT_W-1:0]  nbit_q;
  logic [ICNT_W-1:0] icnt_q;

  // named internal events
  logic need_byte, byte_fire, step_fire, last_step, start_take;

  logic [IDX_W-1:0] tbl_idx;
  logic [LIT_W:0]   sym_nx, off_nx, mref_nx;
  prob_t            prob_rd, prob_wr;
  logic             dec_bit;
  word_t            eng_rng, eng_code;

  assign need_byte  = needs_byte(rng_q);
  assign in_ready   = (st_q == ST_LOAD) || (st_q == ST_DEC && need_byte);
  assign byte_fire  = in_ready && in_valid;
  assign step_fire  = (st_q == ST_DEC) && !need_byte;
  assign last_step  = (nbit_q == CNT_W'(LIT_W - 1));
  assign start_take = start && (st_q == ST_IDLE);

  lit_match_steer #(.LIT_W(LIT_W), .IDX_W(IDX_W)) u_steer (
    .sym_i (sym_q),
    .off_i (off_q),
    .mref_i(mref_q),
    .bit_i (dec_bit),
    .idx_o (tbl_idx),
    .mref_o(mref_nx),
    .sym_o (sym_nx),
    .off_o (off_nx)
  );

  lit_prob_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (tbl_idx),
    .rd_prob(prob_rd),
    .wr_en  (step_fire),
    .wr_idx (tbl_idx),
    .wr_prob(prob_wr)
  );

  lit_bit_engine u_engine (
    .rng_i (rng_q),
    .code_i(code_q),
    .prob_i(prob_rd),
    .bit_o (dec_bit),
    .rng_o (eng_rng),
    .code_o(eng_code),
    .prob_o(prob_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_LOAD;
      rng_q   <= '1;
      code_q  <= '0;
      sym_q   <= '0;
      off_q   <= '0;
      mref_q  <= '0;
      nbit_q  <= '0;
      icnt_q  <= '0;
      literal <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_LOAD: begin
          if (byte_fire) begin
            code_q <= {code_q[WORD_W-BYTE_W-1:0], in_data};
            if (icnt_q == ICNT_W'(INIT_BYTES - 1)) begin
              icnt_q <= '0;
              st_q   <= ST_IDLE;
            end else begin
              icnt_q <= icnt_q + 1'b1;
            end
          end
        end
        ST_IDLE: begin
          if (start_take) begin
            sym_q  <= (LIT_W+1)'(1);
            off_q  <= OFF_START;
            mref_q <= {1'b0, match_byte};
            nbit_q <= '0;
            st_q   <= ST_DEC;
          end
        end
        ST_DEC: begin
          if (byte_fire) begin
            rng_q  <= {rng_q[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
            code_q <= {code_q[WORD_W-BYTE_W-1:0], in_data};
          end else if (step_fire) begin
            rng_q  <= eng_rng;
            code_q <= eng_code;
            sym_q  <= sym_nx;
            off_q  <= off_nx;
            mref_q <= mref_nx;
            nbit_q <= nbit_q + 1'b1;
            if (last_step) begin
              literal <= sym_nx[LIT_W-1:0];
              done    <= 1'b1;
              st_q    <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a cleared steering offset stays cleared for the rest of the literal
  assert_offset_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEC && off_q == '0) |=> (off_q == '0));

  // R7: without steering, only the plain tree is addressed
  assert_plain_tree_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && off_q == '0) |-> (tbl_idx < PLAIN_LIMIT));

  // R8: every addressed entry lies inside 1..top of the table
  assert_index_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> (tbl_idx != '0 && tbl_idx <= TOP_INDEX));

  // R10: a starved decoder keeps its coder state
  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEC && in_ready && !in_valid) |=>
      ($stable(rng_q) && $stable(code_q) && $stable(sym_q) && $stable(off_q)));

  // R3: start during the opening phase never launches a decode
  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_q == ST_LOAD) |=> (st_q != ST_DEC));

  // R2: no stream byte is taken while idle
  assert_idle_no_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |=> ($stable(code_q) && $stable(rng_q)));
endmodule

// File: tb/tb_lit_match_decoder.sv
`timescale 1ns/1ps
module tb_lit_match_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] match_byte = 8'h00;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] literal;
  logic       done;

  always #5 clk = ~clk;

  lit_match_decoder dut (
    .clk(clk), .rst_n(rst_n), .start(start), .match_byte(match_byte),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .literal(literal), .done(done)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // ---------------- reference encoder with its own model ----------------
  logic [7:0]  stream [$];
  int          e_prob [768];
  logic [31:0] e_rng;
  logic [32:0] e_low;
  logic [7:0]  e_cache;
  int          e_csize;

  task automatic shift_low();
    if (e_low[32] || e_low[31:24] != 8'hFF) begin
      logic [7:0] tmp;
      tmp = e_cache;
      do begin
        stream.push_back(tmp + {7'd0, e_low[32]});
        tmp = 8'hFF;
        e_csize--;
      end while (e_csize != 0);
      e_cache = e_low[31:24];
    end
    e_csize++;
    e_low = {1'b0, e_low[23:0], 8'h00};
  endtask

  task automatic enc_bit(int idx, int b);
    logic [31:0] bnd;
    bnd = (e_rng >> 11) * 32'(e_prob[idx]);
    if (b == 0) begin
      e_rng = bnd;
      e_prob[idx] += (2048 - e_prob[idx]) >> 5;
    end else begin
      e_low = e_low + {1'b0, bnd};
      e_rng = e_rng - bnd;
      e_prob[idx] -= e_prob[idx] >> 5;
    end
    while (e_rng < 32'h0100_0000) begin
      e_rng = e_rng << 8;
      shift_low();
    end
  endtask

  task automatic enc_lit(int lit, int mt);
    int sym, off, mb, mbit, b;
    sym = 1; off = 256; mb = mt;
    for (int i = 7; i >= 0; i--) begin
      mb   = mb << 1;
      mbit = mb & off;
      b    = (lit >> i) & 1;
      enc_bit(off + mbit + sym, b);
      sym  = sym * 2 + b;
      off  = (b != 0) ? (off & mbit) : (off & ~mbit);
    end
  endtask

  // ---------------- literal plan ----------------
  int    lits [$];
  int    mts  [$];
  string tags [$];

  task automatic add(int l, int m, string t);
    lits.push_back(l & 255); mts.push_back(m & 255); tags.push_back(t);
  endtask

  // ---------------- byte feeder ----------------
  int         rd_ptr = 0;
  bit         hold_feed = 1'b1;
  bit         fire_pend = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (fire_pend) rd_ptr++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid = !hold_feed && (rd_ptr < stream.size()) && (lfsr[1:0] != 2'b00);
      in_data  = (rd_ptr < stream.size()) ? stream[rd_ptr] : 8'h00;
      #1 fire_pend = in_valid && in_ready;
    end
  end

  // ---------------- done monitor ----------------
  int         done_cnt = 0;
  logic [7:0] last_lit = 8'h00;
  bit         prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) check(1'b0, "R9 done longer than one cycle", 1, 0);
      if (done) begin
        done_cnt++;
        last_lit = literal;
      end
      prev_done = done;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    logic [15:0] pr;
    int base, t;

    // build plan
    for (int v = 0; v < 256; v++) add(v, v, "R6 R7 full match");
    for (int v = 0; v < 256; v++) add(v, v ^ 8'h80, "R7 first-bit mismatch");
    for (int v = 0; v < 256; v++) add(v, v ^ 8'h01, "R7 last-bit mismatch");
    for (int v = 0; v < 256; v++) add(v, v ^ 8'h10, "R7 mid mismatch");
    pr = 16'h1D2B;
    for (int k = 0; k < 200; k++) begin
      pr = {pr[14:0], pr[15] ^ pr[13] ^ pr[12] ^ pr[10]};
      add(pr[7:0], pr[15:8], "R4 R5 mixed pair");
    end
    for (int k = 0; k < 150; k++) add(8'h5A, 8'h5A, "R4 R8 saturating run");
    for (int k = 0; k < 50; k++)  add(8'hA5, 8'h5A, "R4 R8 after skew");

    // encode whole plan
    for (int i = 0; i < 768; i++) e_prob[i] = 1024;
    e_rng = 32'hFFFF_FFFF; e_low = '0; e_cache = 8'h00; e_csize = 1;
    foreach (lits[i]) enc_lit(lits[i], mts[i]);
    repeat (5) shift_low();
    repeat (8) stream.push_back(8'h00);

    // reset, R1
    repeat (3) @(negedge clk);
    #2;
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(literal == 8'h00, "R1 literal in reset", literal, 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    check(done == 1'b0, "R1 done after reset", done, 0);

    // R3: start while still loading, feed held back
    start = 1'b1; match_byte = 8'h33;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    #2;
    check(done_cnt == 0, "R3 start during load", done_cnt, 0);
    check(in_ready == 1'b1, "R3 still loading", in_ready, 1);

    // R2: exactly five opening bytes
    hold_feed = 1'b0;
    wait (rd_ptr == 5);
    @(negedge clk); #2;
    check(in_ready == 1'b0, "R2 ready low when idle", in_ready, 0);
    repeat (6) @(negedge clk);
    #2;
    check(rd_ptr == 5, "R2 no bytes taken while idle", rd_ptr, 5);
    check(done_cnt == 0, "R3 no decode from stray start", done_cnt, 0);

    // decode the plan
    foreach (lits[i]) begin
      base = done_cnt;
      @(negedge clk);
      start = 1'b1; match_byte = mts[i][7:0];
      @(negedge clk);
      start = 1'b0;
      if (i == 10 || i == 400) begin
        @(negedge clk);
        start = 1'b1; match_byte = ~mts[i][7:0];
        @(negedge clk);
        start = 1'b0;
      end
      if (i == 300 || i == 900) begin
        hold_feed = 1'b1;
        repeat (40) @(negedge clk);
        hold_feed = 1'b0;
      end
      t = 0;
      while (done_cnt == base && t < 3000) begin
        @(negedge clk);
        t++;
      end
      #2;
      if (i == 10 || i == 400)
        check(last_lit == lits[i][7:0], "R3 start mid-decode", last_lit, lits[i]);
      else if (i == 300 || i == 900)
        check(last_lit == lits[i][7:0], "R10 long stall", last_lit, lits[i]);
      else
        check(last_lit == lits[i][7:0], tags[i], last_lit, lits[i]);
      check(done_cnt == base + 1, "R9 one done per literal", done_cnt, base + 1);
    end
    repeat (4) @(negedge clk);
    check(done_cnt == lits.size(), "R3 R9 total done pulses", done_cnt, lits.size());

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule